// File: doc/BRIEF.md
# Reservation Address Snoop Filter

This block lives in a second-level cache controller, between a processor-side bus and a system bus. It holds the line address of one processor's outstanding load-reserve reservation, together with a valid flag, and compares every system-bus snoop and every line fill against it. Without such a register, every cycle that could disturb a reservation would have to be retried and passed upward. With it, only the cycles that hit the reserved line are.

The reservation is loaded in one of two ways. On a read-atomic miss, the address comes from the address phase of that read-atomic transaction, and it becomes live when the processor's reservation indicator is high in the cycle after the address acknowledge. On a cache hit, the processor issues an address-only set-reservation transaction. An address-only store-conditional transaction drops the reservation early. The filter still behaves correctly if that transaction never comes: a stale reservation only costs extra retries.

A snoop that hits the reserved line is retried. If its type can disturb the reservation, it is also forwarded to the processor side, and that forward ends the reservation. A fill that hits the reserved line is marked shared rather than exclusive.

Top module: `rsv_snoop_filter`

## Requirements
- R1: A read-atomic processor transaction (`cpu_kind` 2'b00) records its line address. The reservation becomes valid on that line only if `cpu_rsv_ind` is high in the cycle right after a cycle with `cpu_aack` high. If the indicator is low in that cycle, no reservation is made.
- R2: A set-reservation processor transaction (`cpu_kind` 2'b01) makes the reservation valid on the line of `cpu_addr`. It replaces any earlier reservation.
- R3: A store-conditional processor transaction (`cpu_kind` 2'b10) clears the reservation. Without it, a reservation stays valid for any number of idle cycles.
- R4: `snp_fwd` is raised only for a valid snoop that hits the reservation and whose type can modify it: 2'b01 read-with-intent-to-modify, 2'b10 write, or 2'b11 kill. A plain read (2'b00) that hits is never forwarded.
- R5: `snp_retry` is raised for a valid snoop of any type that hits a valid reservation. It is never raised for a snoop that misses, or when no reservation is held.
- R6: `fill_shared` is raised for a valid fill whose line hits a valid reservation. Otherwise it stays low, and the fill may be exclusive.
- R7: Matching uses the line granule. Address bits below log2(`LINE_BYTES`) (default 32 bytes, bits [4:0]) are ignored, and all bits above them must be equal.
- R8: A snoop that is forwarded clears the reservation at the same clock edge, so a later snoop to that line is not retried.
- R9: When a set and a hitting modifying snoop occur in the same cycle, the snoop is judged against the old reservation and the new reservation is kept valid.
- R10: Reset clears the reservation and drives all three outputs low. Each output is registered and reflects the inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor-side transaction valid |
| cpu_kind | input | 2 | 00 read-atomic, 01 set-reservation, 10 store-conditional clear, 11 other |
| cpu_addr | input | AW | Processor-side transaction address |
| cpu_aack | input | 1 | Address acknowledge of a read-atomic transaction |
| cpu_rsv_ind | input | 1 | Processor reservation indicator, sampled in the cycle after `cpu_aack` |
| snp_valid | input | 1 | System-bus snoop valid |
| snp_kind | input | 2 | 00 read, 01 read-with-intent-to-modify, 10 write, 11 kill |
| snp_addr | input | AW | Snooped address |
| fill_valid | input | 1 | Line fill request valid |
| fill_addr | input | AW | Line fill address |
| snp_retry | output | 1 | Retry the previous cycle's snoop |
| snp_fwd | output | 1 | Forward the previous cycle's snoop to the processor side |
| fill_shared | output | 1 | Previous cycle's fill must be installed shared |

## Verification
A snoop or fill presented in one cycle produces its `snp_retry`, `snp_fwd` or `fill_shared` result right after the next rising edge. A set or clear made in one cycle governs the snoops of the following cycle onward. The read-atomic path takes one further cycle: first the address, then the acknowledge, then the indicator cycle. After that, a snoop one cycle later sees the new reservation. The bench's driver computes one expected result for every cycle it drives and queues it. The monitor takes one item 1 ns after each rising edge, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/rsv_filter_pkg.sv
package rsv_filter_pkg;

  typedef enum logic [1:0] {
    CPU_RD_ATOMIC = 2'b00,
    CPU_SET_RSV   = 2'b01,
    CPU_STCX_CLR  = 2'b10,
    CPU_OTHER     = 2'b11
  } cpu_kind_e;

  typedef enum logic [1:0] {
    SNP_READ  = 2'b00,
    SNP_RWITM = 2'b01,
    SNP_WRITE = 2'b10,
    SNP_KILL  = 2'b11
  } snp_kind_e;

  // Snoop types that can destroy a held reservation.
  function automatic logic kills_rsv(input snp_kind_e k);
    return k != SNP_READ;
  endfunction

endpackage

// File: rtl/rsv_line_cmp.sv
module rsv_line_cmp #(
  parameter int LW = 27
) (
  input  logic          held_ok,
  input  logic [LW-1:0] held_line,
  input  logic          probe_ok,
  input  logic [LW-1:0] probe_line,
  output logic          hit
);
  function automatic logic same_line(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return a == b;
  endfunction

  assign hit = held_ok && probe_ok && same_line(held_line, probe_line);
endmodule

// File: rtl/rsv_state.sv
module rsv_state #(
  parameter int LW = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [LW-1:0] set_line,
  input  logic          clr_en,
  output logic          valid,
  output logic [LW-1:0] line
);
  // Set takes priority over any clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      line  <= '0;
    end else if (set_en) begin
      valid <= 1'b1;
      line  <= set_line;
    end else if (clr_en) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rsv_resp.sv
module rsv_resp #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/rsv_snoop_filter.sv
module rsv_snoop_filter
  import rsv_filter_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic [1:0]    cpu_kind,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_aack,
  input  logic          cpu_rsv_ind,
  input  logic          snp_valid,
  input  logic [1:0]    snp_kind,
  input  logic [AW-1:0] snp_addr,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_addr,
  output logic          snp_retry,
  output logic          snp_fwd,
  output logic          fill_shared
);
  localparam int OFS    = $clog2(LINE_BYTES);
  localparam int LW     = AW - OFS;
  localparam int NPROBE = 2;

  cpu_kind_e ck;
  snp_kind_e sk;
  assign ck = cpu_kind_e'(cpu_kind);
  assign sk = snp_kind_e'(snp_kind);

  logic [LW-1:0] cpu_line, pend_line, rsv_line;
  logic          aack_d, rsv_valid;
  logic          unused_ofs;
  assign cpu_line   = cpu_addr[AW-1:OFS];
  assign unused_ofs = ^{cpu_addr[OFS-1:0], snp_addr[OFS-1:0], fill_addr[OFS-1:0]};

  // Read-atomic address capture and acknowledge delay.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_line <= '0;
      aack_d    <= 1'b0;
    end else begin
      if (cpu_valid && ck == CPU_RD_ATOMIC) pend_line <= cpu_line;
      aack_d <= cpu_aack;
    end
  end

  // Named internal events.
  logic          set_txn, set_latch, set_evt, stcx_evt, kill_evt, clr_evt;
  logic [LW-1:0] set_line;
  logic          snp_hit, fill_hit;

  assign set_txn   = cpu_valid && ck == CPU_SET_RSV;
  assign set_latch = aack_d && cpu_rsv_ind;
  assign set_evt   = set_txn || set_latch;
  assign set_line  = set_txn ? cpu_line : pend_line;
  assign stcx_evt  = cpu_valid && ck == CPU_STCX_CLR;
  assign kill_evt  = snp_hit && kills_rsv(sk);
  assign clr_evt   = stcx_evt || kill_evt;

  // Probe comparators: index 0 snoop, index 1 fill.
  logic [NPROBE-1:0]         probe_ok, probe_hit;
  logic [NPROBE-1:0][LW-1:0] probe_line;
  assign probe_ok[0]   = snp_valid;
  assign probe_line[0] = snp_addr[AW-1:OFS];
  assign probe_ok[1]   = fill_valid;
  assign probe_line[1] = fill_addr[AW-1:OFS];

  for (genvar g = 0; g < NPROBE; g++) begin : g_cmp
    rsv_line_cmp #(.LW(LW)) u_cmp (
      .held_ok    (rsv_valid),
      .held_line  (rsv_line),
      .probe_ok   (probe_ok[g]),
      .probe_line (probe_line[g]),
      .hit        (probe_hit[g])
    );
  end
  assign snp_hit  = probe_hit[0];
  assign fill_hit = probe_hit[1];

  rsv_state #(.LW(LW)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_evt),
    .set_line (set_line),
    .clr_en   (clr_evt),
    .valid    (rsv_valid),
    .line     (rsv_line)
  );

  logic [2:0] resp_d, resp_q;
  assign resp_d = {fill_hit, kill_evt, snp_hit};

  rsv_resp #(.W(3)) u_resp (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (resp_d),
    .q     (resp_q)
  );

  assign snp_retry   = resp_q[0];
  assign snp_fwd     = resp_q[1];
  assign fill_shared = resp_q[2];
endmodule

// File: rtl/rsv_filter_chk.sv
module rsv_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_valid,
  input logic [1:0] cpu_kind,
  input logic       snp_valid,
  input logic [1:0] snp_kind,
  input logic       fill_valid,
  input logic       snp_retry,
  input logic       snp_fwd,
  input logic       fill_shared,
  input logic       set_evt,
  input logic       rsv_valid
);
  AST_RETRY_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> $past(snp_valid)); // R5
  AST_FWD_IMPLIES_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_fwd |-> snp_retry); // R4
  AST_FWD_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    snp_fwd |-> $past(snp_kind) != 2'b00); // R4
  AST_FWD_DROPS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_fwd && !$past(set_evt)) |-> !rsv_valid); // R8
  AST_STCX_DROPS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_kind == 2'b10 && !set_evt) |=> !rsv_valid); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> rsv_valid); // R9
  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsv_valid |=> (!snp_retry && !fill_shared)); // R5
  AST_SHARED_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_shared |-> $past(fill_valid)); // R6
endmodule

bind rsv_snoop_filter rsv_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_valid   (cpu_valid),
  .cpu_kind    (cpu_kind),
  .snp_valid   (snp_valid),
  .snp_kind    (snp_kind),
  .fill_valid  (fill_valid),
  .snp_retry   (snp_retry),
  .snp_fwd     (snp_fwd),
  .fill_shared (fill_shared),
  .set_evt     (set_evt),
  .rsv_valid   (rsv_valid)
);

// File: tb/tb_rsv_snoop_filter.sv
module tb_rsv_snoop_filter;
  localparam int AW = 32;
  localparam int SH = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cpu_valid = 1'b0, cpu_aack = 1'b0, cpu_rsv_ind = 1'b0;
  logic [1:0]    cpu_kind = 2'b11, snp_kind = 2'b00;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0, fill_addr = '0;
  logic          snp_valid = 1'b0, fill_valid = 1'b0;
  logic          snp_retry, snp_fwd, fill_shared;

  rsv_snoop_filter dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr),
    .cpu_aack(cpu_aack), .cpu_rsv_ind(cpu_rsv_ind),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .snp_retry(snp_retry), .snp_fwd(snp_fwd), .fill_shared(fill_shared)
  );

  typedef struct { logic r; logic f; logic s; string tag; } exp_t;
  exp_t q[$];
  int n_tests = 0, n_fail = 0;

  // Next-cycle stimulus, reset to idle after each step.
  logic          nx_rst = 1'b0, nx_cv = 1'b0, nx_aack = 1'b0, nx_ind = 1'b0;
  logic          nx_sv = 1'b0, nx_fv = 1'b0;
  logic [1:0]    nx_ck = 2'b11, nx_sk = 2'b00;
  logic [AW-1:0] nx_ca = '0, nx_sa = '0, nx_fa = '0;

  // Requirement-level model state.
  logic          m_v = 1'b0, m_ad = 1'b0;
  logic [AW-1:0] m_line = '0, m_pend = '0;

  task automatic step(input string tag);
    exp_t e;
    logic hs, hf, set_now, clr_now;
    logic [AW-1:0] nl;
    @(negedge clk);
    rst_n = nx_rst; cpu_valid = nx_cv; cpu_kind = nx_ck; cpu_addr = nx_ca;
    cpu_aack = nx_aack; cpu_rsv_ind = nx_ind;
    snp_valid = nx_sv; snp_kind = nx_sk; snp_addr = nx_sa;
    fill_valid = nx_fv; fill_addr = nx_fa;
    e.tag = tag;
    if (!nx_rst) begin
      e.r = 0; e.f = 0; e.s = 0;
      m_v = 0; m_ad = 0; m_line = '0; m_pend = '0;
    end else begin
      hs = m_v && nx_sv && ((nx_sa >> SH) == m_line);
      hf = m_v && nx_fv && ((nx_fa >> SH) == m_line);
      e.r = hs; e.f = hs && (nx_sk != 2'b00); e.s = hf;
      set_now = (nx_cv && nx_ck == 2'b01) || (m_ad && nx_ind);
      nl = (nx_cv && nx_ck == 2'b01) ? (nx_ca >> SH) : m_pend;
      clr_now = e.f || (nx_cv && nx_ck == 2'b10);
      if (set_now) begin m_v = 1; m_line = nl; end
      else if (clr_now) m_v = 0;
      if (nx_cv && nx_ck == 2'b00) m_pend = nx_ca >> SH;
      m_ad = nx_aack;
    end
    q.push_back(e);
    nx_cv = 0; nx_ck = 2'b11; nx_aack = 0; nx_ind = 0; nx_sv = 0; nx_fv = 0;
  endtask

  task automatic cpu(input logic [1:0] k, input logic [AW-1:0] a);
    nx_cv = 1; nx_ck = k; nx_ca = a;
  endtask
  task automatic snoop(input logic [1:0] k, input logic [AW-1:0] a);
    nx_sv = 1; nx_sk = k; nx_sa = a;
  endtask
  task automatic fill(input logic [AW-1:0] a);
    nx_fv = 1; nx_fa = a;
  endtask

  // Monitor: one expected item per rising edge, 1 ns after it.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if ({snp_retry, snp_fwd, fill_shared} !== {e.r, e.f, e.s}) begin
        n_fail++;
        $display("FAIL %s: retry/fwd/shared actual %b%b%b expected %b%b%b",
                 e.tag, snp_retry, snp_fwd, fill_shared, e.r, e.f, e.s);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state, outputs low
    nx_rst = 0; snoop(2'b11, 32'h0); step("R10 reset");
    step("R10 reset");
    nx_rst = 1; step("R10 idle after reset");
    snoop(2'b01, 32'h0); fill(32'h0); step("R10 no reservation after reset");

    // R2 set-reservation, R5 retry on hit, R7 granule
    cpu(2'b01, 32'h0000_1000); step("R2 set");
    snoop(2'b00, 32'h0000_1004); step("R5 read hit retried, R4 not forwarded");
    snoop(2'b00, 32'h0000_101F); step("R7 offset bits ignored");
    snoop(2'b00, 32'h0000_1020); step("R7 next line misses");
    snoop(2'b01, 32'h8000_1000); step("R7 upper bit differs");
    fill(32'h0000_101C); step("R6 fill hit shared");
    fill(32'h0000_2000); step("R6 fill miss exclusive");

    // R4 / R8 modifying hit forwarded and clears
    snoop(2'b10, 32'h0000_1008); step("R4 write hit forwarded");
    snoop(2'b00, 32'h0000_1000); step("R8 cleared after forward");
    fill(32'h0000_1000); step("R8 fill exclusive after forward");

    // R1 read-atomic path
    cpu(2'b00, 32'h0000_3000); step("R1 read-atomic address");
    nx_aack = 1; step("R1 aack");
    nx_ind = 1; snoop(2'b00, 32'h0000_3000); step("R1 not yet live");
    snoop(2'b11, 32'h0000_3010); step("R1 live, kill forwarded");
    cpu(2'b00, 32'h0000_4000); step("R1 second read-atomic");
    nx_aack = 1; step("R1 aack");
    nx_ind = 0; step("R1 indicator low");
    snoop(2'b01, 32'h0000_4000); step("R1 no reservation when indicator low");

    // R3 persistence and store-conditional clear
    cpu(2'b01, 32'h0000_5000); step("R3 set");
    for (int i = 0; i < 20; i++) step("R3 idle");
    snoop(2'b00, 32'h0000_5000); step("R3 still held");
    cpu(2'b10, 32'h0000_5000); step("R3 store-conditional");
    snoop(2'b00, 32'h0000_5000); step("R3 cleared");

    // R9 set versus same-cycle kill
    cpu(2'b01, 32'h0000_6000); step("R9 set old");
    cpu(2'b01, 32'h0000_7000); snoop(2'b11, 32'h0000_6000); step("R9 old line forwarded");
    snoop(2'b00, 32'h0000_7000); step("R9 new reservation kept");
    cpu(2'b01, 32'h0000_8000); snoop(2'b11, 32'h0000_8000); step("R9 kill vs old only");
    snoop(2'b10, 32'h0000_8000); step("R9 new line live");
    step("R10 idle");

    repeat (3) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule